// File: doc/BRIEF.md
# Interrupt Vector Dispatch and Context Unit

This unit turns an accepted interrupt or trap into a complete entry sequence. Each source carries a 5-bit vector number. The unit doubles that vector and adds it to a table base address. It reads the service routine's start address from that table slot. It saves the interrupted program counter and status word on an interrupt stack that grows toward address zero. It then presents the new program counter to the core as a one-cycle load.

A return strobe runs the reverse sequence. The saved status word and program counter are read back from the stack, both are handed to the core in a single load cycle, and the stack pointer moves back up.

A non-maskable interrupt pin is also handled here. It is asynchronous and active on a falling edge. The pin passes through an internal two-flop synchronizer and an edge detector, and a detected edge sets a pending flag. The pin has no effect until the core raises the enable input, which is low out of reset.

The memory port is byte addressed with 16-bit words. Reads are synchronous: the data appears on `mem_rdata` in the cycle after `mem_re`.

Top module: `irq_dispatch`

## Requirements
- R1: Entry reads the table word at byte address `intbase + 2*vector`. This read is the first memory access after acceptance, one cycle after the accepting edge, and vector values 0 to 31 are all valid.
- R2: Entry then writes two stack words on consecutive cycles: first the captured PC at `isp-2`, then the captured PSR at `isp-4`. `isp_out` reads four lower once the second write is done, and no write ever targets any other address.
- R3: Four cycles after the accepting edge, `pc_load` is high for exactly one cycle, `psr_load` stays low, and `pc_out` carries the word read from the table.
- R4: A return strobe reads the PSR at `isp`, then the PC at `isp+2`. It then gives one cycle with both `pc_load` and `psr_load` high, carrying those two values. `isp_out` rises by four at the end of that cycle.
- R5: `busy` is high from the cycle after acceptance until the sequence ends. Requests, return strobes and stack-pointer writes seen while busy cause no memory access and no load. No memory access or load occurs while idle.
- R6: A falling edge on `nmi_n` sets a pending flag only while `nmi_en` is high. `nmi_en` is low from reset. Edges that arrive while it is low are dropped, and lowering it clears a pending flag.
- R7: A pending, enabled non-maskable interrupt runs as vector 1. It is taken ahead of a maskable request presented in the same idle cycle, and that request is served afterwards if it is still held.
- R8: In the idle state `isp_wr` loads `isp_wdata` into the stack pointer. It outranks every other request in that cycle, and the priority order is stack-pointer write, then NMI, then maskable request, then return.
- R9: During and right after reset, `busy`, `mem_re`, `mem_we`, `pc_load` and `psr_load` are low and `isp_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Maskable request or trap present |
| req_vec | input | 5 | Vector number of the request |
| nmi_n | input | 1 | Asynchronous non-maskable interrupt pin, falling-edge active |
| nmi_en | input | 1 | Non-maskable interrupt enable from software |
| ret_stb | input | 1 | Return-from-exception command |
| isp_wr | input | 1 | Load the interrupt stack pointer |
| isp_wdata | input | 16 | New interrupt stack pointer value |
| intbase | input | 16 | Dispatch table base address |
| pc_in | input | 16 | Current program counter |
| psr_in | input | 16 | Current status word |
| pc_out | output | 16 | Program counter to load |
| psr_out | output | 16 | Status word to load |
| pc_load | output | 1 | Load strobe for `pc_out` |
| psr_load | output | 1 | Load strobe for `psr_out` |
| mem_addr | output | 16 | Memory byte address |
| mem_re | output | 1 | Memory read (data next cycle) |
| mem_we | output | 1 | Memory write |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | A sequence is running |
| isp_out | output | 16 | Current interrupt stack pointer |

## Verification
A wrong sequencer state shows up at the memory port within a cycle or two: an access would arrive out of order, at the wrong address, or while idle. The scoreboard catches that at the very next event. A stack pointer that drifts shows first in the address of the next push or pop, and later in the value a return hands back, because the stack words are really stored and read again. A faulty edge detector or pending flag shows as an entry that was never asked for, or as a missing vector-1 table read about four cycles after the pin falls.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int VW      = 5,
  parameter int NMI_VEC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vec,
  input  logic          nmi_n,
  input  logic          nmi_en,
  input  logic          ret_stb,
  input  logic          isp_wr,
  input  logic [AW-1:0] isp_wdata,
  input  logic [AW-1:0] intbase,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] psr_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] psr_out,
  output logic          pc_load,
  output logic          psr_load,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [AW-1:0] isp_out
);

  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);
  localparam logic [AW-1:0] FRAME = AW'(2 * (DW / 8));

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PUSH_PC, S_PUSH_PSR, S_LOAD_PC, S_POP_PSR, S_POP_PC, S_RET_LOAD
  } st_t;

  st_t           st;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] pc_q, psr_q, tgt_q;
  logic [AW-1:0] isp_q;
  logic          nmi_s1, nmi_s2, nmi_prev, nmi_pend;

  wire idle     = (st == S_IDLE);
  wire nmi_fall = nmi_prev & ~nmi_s2;
  wire nmi_live = nmi_pend & nmi_en;
  wire open_gap = idle & ~isp_wr;
  wire nmi_go   = open_gap & nmi_live;
  wire req_go   = open_gap & ~nmi_live & req_valid;
  wire ret_go   = open_gap & ~nmi_live & ~req_valid & ret_stb;

  wire [AW-1:0] tbl_addr = intbase + AW'({vec_q, 1'b0});

  assign busy     = ~idle;
  assign isp_out  = isp_q;
  assign pc_load  = (st == S_LOAD_PC) | (st == S_RET_LOAD);
  assign psr_load = (st == S_RET_LOAD);
  assign pc_out   = (st == S_RET_LOAD) ? mem_rdata : tgt_q;
  assign psr_out  = psr_q;

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_FETCH:    begin mem_re = 1'b1; mem_addr = tbl_addr; end
      S_PUSH_PC:  begin mem_we = 1'b1; mem_addr = isp_q - WSTEP; mem_wdata = pc_q; end
      S_PUSH_PSR: begin mem_we = 1'b1; mem_addr = isp_q - FRAME; mem_wdata = psr_q; end
      S_POP_PSR:  begin mem_re = 1'b1; mem_addr = isp_q; end
      S_POP_PC:   begin mem_re = 1'b1; mem_addr = isp_q + WSTEP; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_s1   <= 1'b1;
      nmi_s2   <= 1'b1;
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_s1   <= nmi_n;
      nmi_s2   <= nmi_s1;
      nmi_prev <= nmi_s2;
      if (!nmi_en)       nmi_pend <= 1'b0;
      else if (nmi_fall) nmi_pend <= 1'b1;
      else if (nmi_go)   nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      vec_q <= '0;
      pc_q  <= '0;
      psr_q <= '0;
      tgt_q <= '0;
      isp_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (isp_wr) isp_q <= isp_wdata;
          if (nmi_go || req_go) begin
            vec_q <= nmi_go ? VW'(NMI_VEC) : req_vec;
            pc_q  <= pc_in;
            psr_q <= psr_in;
            st    <= S_FETCH;
          end else if (ret_go) begin
            st <= S_POP_PSR;
          end
        end
        S_FETCH:    st <= S_PUSH_PC;
        S_PUSH_PC:  begin tgt_q <= mem_rdata; st <= S_PUSH_PSR; end
        S_PUSH_PSR: begin isp_q <= isp_q - FRAME; st <= S_LOAD_PC; end
        S_LOAD_PC:  st <= S_IDLE;
        S_POP_PSR:  st <= S_POP_PC;
        S_POP_PC:   begin psr_q <= mem_rdata; st <= S_RET_LOAD; end
        S_RET_LOAD: begin isp_q <= isp_q + FRAME; st <= S_IDLE; end
        default:    st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          pc_load,
  input logic          psr_load,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] isp_out,
  input logic          nmi_en,
  input logic          nmi_pend
);

  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);
  localparam logic [AW-1:0] FRAME = AW'(2 * (DW / 8));

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_entry_isp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !psr_load) |-> isp_out == $past(isp_out) - FRAME);

  p_write_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == isp_out - WSTEP || mem_addr == isp_out - FRAME));

  p_ret_isp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psr_load |=> isp_out == $past(isp_out) + FRAME);

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !pc_load));

  p_nmi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |=> !nmi_pend);

endmodule

bind irq_dispatch irq_dispatch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .pc_load  (pc_load),
  .psr_load (psr_load),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .isp_out  (isp_out),
  .nmi_en   (nmi_en),
  .nmi_pend (nmi_pend)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_vec = '0;
  logic nmi_n = 1'b1;
  logic nmi_en = 1'b0;
  logic ret_stb = 1'b0;
  logic isp_wr = 1'b0;
  logic [15:0] isp_wdata = '0;
  logic [15:0] intbase = BASE;
  logic [15:0] pc_in = '0, psr_in = '0;
  logic [15:0] pc_out, psr_out, mem_addr, mem_wdata, isp_out;
  logic [15:0] mem_rdata = '0;
  logic pc_load, psr_load, mem_re, mem_we, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .nmi_n(nmi_n), .nmi_en(nmi_en), .ret_stb(ret_stb), .isp_wr(isp_wr),
    .isp_wdata(isp_wdata), .intbase(intbase), .pc_in(pc_in), .psr_in(psr_in),
    .pc_out(pc_out), .psr_out(psr_out), .pc_load(pc_load), .psr_load(psr_load),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .isp_out(isp_out)
  );

  logic [15:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:1]];
  end

  typedef struct packed {
    logic [1:0]  k;
    logic [15:0] a;
    logic [15:0] d0;
    logic [15:0] d1;
  } ev_t;

  ev_t   expq[$];
  string tagq[$];
  logic [31:0] stk[$];
  logic [15:0] isp_m = '0;
  int total = 0, bad = 0;
  bit saw_busy = 0, done = 0;

  function automatic logic [15:0] tgt(int v);
    return 16'hA000 + 16'(v * 16);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_ev(logic [1:0] k, logic [15:0] a, logic [15:0] d0, logic [15:0] d1, string t);
    expq.push_back('{k: k, a: a, d0: d0, d1: d1});
    tagq.push_back(t);
  endtask

  task automatic exp_irq(int v, logic [15:0] pc, logic [15:0] psr);
    push_ev(2'd0, BASE + 16'(2 * v), '0, '0, "R1 table read");
    push_ev(2'd1, isp_m - 16'd2, pc, '0, "R2 pc push");
    push_ev(2'd1, isp_m - 16'd4, psr, '0, "R2 psr push");
    push_ev(2'd2, '0, tgt(v), '0, "R3 pc load");
    stk.push_back({pc, psr});
    isp_m = isp_m - 16'd4;
  endtask

  task automatic exp_ret();
    logic [31:0] fr;
    fr = stk.pop_back();
    push_ev(2'd0, isp_m, '0, '0, "R4 psr pop read");
    push_ev(2'd0, isp_m + 16'd2, '0, '0, "R4 pc pop read");
    push_ev(2'd3, '0, fr[31:16], fr[15:0], "R4 restore load");
    isp_m = isp_m + 16'd4;
  endtask

  task automatic take_ev(logic [1:0] k, logic [15:0] a, logic [15:0] d0, logic [15:0] d1);
    ev_t e;
    string t;
    bit ok;
    total++;
    if (expq.size() == 0) begin
      bad++;
      $display("FAIL R5 unexpected event kind=%0d: actual addr=%0h data=%0h expected none", k, a, d0);
    end else begin
      e = expq.pop_front();
      t = tagq.pop_front();
      ok = (e.k == k) && (k >= 2'd2 || e.a == a) && (k == 2'd0 || e.d0 == d0)
           && (k != 2'd3 || e.d1 == d1);
      if (!ok) begin
        bad++;
        $display("FAIL %s: actual k=%0d a=%0h d0=%0h d1=%0h expected k=%0d a=%0h d0=%0h d1=%0h",
                 t, k, a, d0, d1, e.k, e.a, e.d0, e.d1);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy) saw_busy = 1;
      if (mem_re) take_ev(2'd0, mem_addr, '0, '0);
      if (mem_we) take_ev(2'd1, mem_addr, mem_wdata, '0);
      if (pc_load) take_ev(psr_load ? 2'd3 : 2'd2, '0, pc_out, psr_load ? psr_out : '0);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic set_isp(logic [15:0] v);
    @(negedge clk);
    isp_wr = 1; isp_wdata = v;
    @(negedge clk);
    isp_wr = 0;
    isp_m = v;
    check(isp_out == v, "R8", "isp load", isp_out, v);
  endtask

  task automatic do_irq(int v, logic [15:0] pc, logic [15:0] psr, bit noise);
    exp_irq(v, pc, psr);
    @(negedge clk);
    req_valid = 1; req_vec = 5'(v); pc_in = pc; psr_in = psr;
    @(negedge clk);
    check(busy == 1, "R5", "busy after accept", busy, 1);
    if (noise) begin
      req_vec = 5'(v ^ 5); ret_stb = 1; isp_wr = 1; isp_wdata = 16'h0040;
    end else req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 0; ret_stb = 0; isp_wr = 0;
    check(pc_load == 1 && psr_load == 0, "R3", "pc_load timing", pc_load, 1);
    @(negedge clk);
    check(busy == 0, "R5", "busy end", busy, 0);
    check(isp_out == isp_m, "R2", "isp after entry", isp_out, isp_m);
  endtask

  task automatic do_ret();
    exp_ret();
    @(negedge clk);
    ret_stb = 1;
    @(negedge clk);
    ret_stb = 0;
    repeat (2) @(negedge clk);
    check(pc_load && psr_load, "R4", "restore load timing", {pc_load, psr_load}, 3);
    @(negedge clk);
    check(isp_out == isp_m, "R4", "isp after return", isp_out, isp_m);
    check(busy == 0, "R5", "busy end after return", busy, 0);
  endtask

  initial begin
    for (int v = 0; v < 32; v++) mem[(BASE >> 1) + v] = tgt(v);
    repeat (3) @(negedge clk);
    check(!busy && !mem_re && !mem_we && !pc_load && !psr_load, "R9", "outputs in reset",
          {busy, mem_re, mem_we, pc_load, psr_load}, 0);
    rst_n = 1;
    @(negedge clk);
    check(isp_out == 16'h0 && !busy, "R9", "state after reset", isp_out, 0);

    set_isp(16'h0300);
    do_irq(5, 16'h1234, 16'h00F1, 0);
    do_irq(31, 16'h2222, 16'h0002, 0);
    do_irq(0, 16'h3333, 16'h0303, 1);
    do_ret();
    do_ret();
    do_ret();

    // R8: stack-pointer write beats a request in the same idle cycle
    @(negedge clk);
    isp_wr = 1; isp_wdata = 16'h0280; req_valid = 1; req_vec = 5'd9;
    @(negedge clk);
    isp_wr = 0; req_valid = 0;
    isp_m = 16'h0280;
    check(isp_out == 16'h0280, "R8", "isp write priority", isp_out, 16'h0280);
    repeat (2) @(negedge clk);
    check(busy == 0, "R8", "request dropped under isp write", busy, 0);

    // R6: edge while disabled is dropped
    saw_busy = 0;
    nmi_en = 0; nmi_n = 0;
    repeat (4) @(negedge clk);
    nmi_n = 1;
    repeat (8) @(negedge clk);
    check(saw_busy == 0, "R6", "disabled nmi ignored", saw_busy, 0);
    nmi_en = 1;
    repeat (4) @(negedge clk);
    check(busy == 0, "R6", "enable alone no entry", busy, 0);

    // R7: nmi pending during a sequence beats a held request
    exp_irq(3, 16'h4444, 16'h0044);
    exp_irq(1, 16'h4444, 16'h0044);
    exp_irq(7, 16'h4444, 16'h0044);
    @(negedge clk);
    req_valid = 1; req_vec = 5'd3; pc_in = 16'h4444; psr_in = 16'h0044;
    @(negedge clk);
    nmi_n = 0; req_vec = 5'd7;
    wait_idle();
    @(negedge clk);
    check(busy == 1, "R7", "nmi entered first", busy, 1);
    wait_idle();
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, "R7", "held request served next", busy, 1);
    wait_idle();
    nmi_n = 1;
    check(isp_out == isp_m, "R7", "isp after three entries", isp_out, isp_m);
    do_ret();
    do_ret();
    do_ret();

    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R5", "no missing events", expq.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule